// File: doc/BRIEF.md
# Load/Store Address Generation and Region Decode

This block turns a memory request from a small 32-bit core into a final bus address. It also classifies that address. Each request carries a register index, the base register value, a signed 16-bit displacement, a flag that marks an instruction fetch, and a flag that marks a write. The block adds the displacement to the base. It then folds or masks the result, depending on whether the request is a data access or a fetch, and compares the address against a fixed set of windows.

For data accesses, bit 25 of the sum is replicated into the top six bits. Because of this, a small negative offset from the zero register reaches the RAM and peripheral windows at the top of the 4 GB space. One pointer of zero then covers ROM, RAM and I/O. For fetches, the top six bits are cleared, and a separate 4 KB window near the top of the 64 MB program space selects RAM.

The result is registered with one cycle of latency behind a valid/ready pair. The result stage holds its content while the consumer stalls.

Top module: `agu_top`

## Requirements
- R1: The effective sum is the base plus the displacement sign-extended to 32 bits, taken modulo 2^32 before any folding or masking.
- R2: When the register index is 0, the base is treated as zero regardless of the value on the base input.
- R3: For a data access, bits 31..26 of the output address equal bit 25 of the sum, and bits 25..0 equal the sum's bits 25..0.
- R4: For a fetch, bits 31..26 of the output address are zero. The write flag has no effect on a fetch.
- R5: Addresses 00000000h..00007FFFh select ROM (select bit 0) for fetches and data reads. A data write there raises the fault flag and leaves every select bit low.
- R6: Data addresses FFFFE000h..FFFFEFFFh, and fetch addresses 03FFE000h..03FFEFFFh, select RAM (select bit 1) with no fault.
- R7: Data addresses FFFFF000h..FFFFFFFFh select peripheral I/O (select bit 2) with no fault.
- R8: Data addresses FFFF8000h..FFFFDFFFh set select bit 3 (prohibited) together with the fault flag.
- R9: Any address outside every window above raises the fault flag with all select bits low. This includes fetches to the data RAM, I/O and prohibited addresses.
- R10: A request accepted on a clock edge appears on the output one edge later. While `rsp_valid` is high and `rsp_ready` is low, the output stays stable and `req_ready` is low. `req_ready` is high when the output is empty or is being drained.
- R11: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with valid |
| req_ridx | input | 5 | Base register index; 0 forces a zero base |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = data write |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Final address |
| rsp_sel | output | 4 | One-hot region: bit0 ROM, bit1 RAM, bit2 I/O, bit3 prohibited |
| rsp_fault | output | 1 | Access fault |

## Verification
The result stage can drain a held result and accept a new request on the same edge. The consumer's ready drops only for a few cycles at a time. The bench provokes this by toggling `rsp_ready` from a pseudo-random sequence while requests are offered back to back. Every result leaving the stage is compared in order against a queue filled at acceptance. On every stalled cycle, the bench also confirms that the output did not move and that `req_ready` stayed low, so any lost, duplicated or overwritten result shows up as a mismatch.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned AGU_ADDR_W  = 32;
  localparam int unsigned AGU_DISP_W  = 16;
  localparam int unsigned AGU_SPACE_W = 26;
  localparam int unsigned AGU_RIDX_W  = 5;

  typedef enum int unsigned {
    RG_ROM  = 0,
    RG_RAM  = 1,
    RG_IO   = 2,
    RG_BAD  = 3,
    RG_NUM  = 4
  } region_e;
endpackage

// File: rtl/agu_rst_sync.sv
module agu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc #(
  parameter int unsigned ADDR_W  = agu_pkg::AGU_ADDR_W,
  parameter int unsigned DISP_W  = agu_pkg::AGU_DISP_W,
  parameter int unsigned SPACE_W = agu_pkg::AGU_SPACE_W,
  parameter int unsigned RIDX_W  = agu_pkg::AGU_RIDX_W
) (
  input  logic [RIDX_W-1:0] ridx,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic              fetch,
  output logic [ADDR_W-1:0] ea
);
  localparam int unsigned TOP_W = ADDR_W - SPACE_W;
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] sum;
  logic [TOP_W-1:0]  top_bits;

  always_comb begin
    // register 0 reads as zero no matter what the file presents
    base_eff = (ridx == '0) ? '0 : base;
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    sum      = base_eff + disp_ext;
    // data: mirror the 64 MB space across 4 GB; fetch: single 64 MB space
    top_bits = fetch ? '0 : {TOP_W{sum[SPACE_W-1]}};
    ea       = {top_bits, sum[SPACE_W-1:0]};
  end
endmodule

// File: rtl/agu_region_decode.sv
module agu_region_decode #(
  parameter int unsigned     ADDR_W  = agu_pkg::AGU_ADDR_W,
  parameter int unsigned     NREG    = agu_pkg::RG_NUM,
  parameter logic [ADDR_W-1:0] ROM_LO  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] ROM_HI  = 32'h0000_7FFF,
  parameter logic [ADDR_W-1:0] FRAM_LO = 32'h03FF_E000,
  parameter logic [ADDR_W-1:0] FRAM_HI = 32'h03FF_EFFF,
  parameter logic [ADDR_W-1:0] DRAM_LO = 32'hFFFF_E000,
  parameter logic [ADDR_W-1:0] DRAM_HI = 32'hFFFF_EFFF,
  parameter logic [ADDR_W-1:0] IO_LO   = 32'hFFFF_F000,
  parameter logic [ADDR_W-1:0] IO_HI   = 32'hFFFF_FFFF,
  parameter logic [ADDR_W-1:0] BAD_LO  = 32'hFFFF_8000,
  parameter logic [ADDR_W-1:0] BAD_HI  = 32'hFFFF_DFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic              write,
  output logic [NREG-1:0]   sel,
  output logic              fault
);
  import agu_pkg::*;

  // modular distance compare: no constant-bound comparisons
  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] span;
    off    = a - lo;
    span   = hi - lo;
    in_win = (off <= span);
  endfunction

  logic hit_rom, hit_fram, hit_dram, hit_io, hit_bad;
  logic [NREG-1:0] sel_raw;

  always_comb begin
    hit_rom  = in_win(addr, ROM_LO,  ROM_HI);
    hit_fram = in_win(addr, FRAM_LO, FRAM_HI);
    hit_dram = in_win(addr, DRAM_LO, DRAM_HI);
    hit_io   = in_win(addr, IO_LO,   IO_HI);
    hit_bad  = in_win(addr, BAD_LO,  BAD_HI);

    sel_raw = '0;
    fault   = 1'b0;
    if (fetch) begin
      if (hit_rom)       sel_raw[RG_ROM] = 1'b1;
      else if (hit_fram) sel_raw[RG_RAM] = 1'b1;
      else               fault = 1'b1;
    end else begin
      if (hit_rom) begin
        if (write) fault = 1'b1;
        else       sel_raw[RG_ROM] = 1'b1;
      end else if (hit_dram) begin
        sel_raw[RG_RAM] = 1'b1;
      end else if (hit_io) begin
        sel_raw[RG_IO] = 1'b1;
      end else if (hit_bad) begin
        sel_raw[RG_BAD] = 1'b1;
        fault           = 1'b1;
      end else begin
        fault = 1'b1;
      end
    end
    sel = sel_raw;
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int unsigned ADDR_W = agu_pkg::AGU_ADDR_W,
  parameter int unsigned NREG   = agu_pkg::RG_NUM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NREG-1:0]   in_sel,
  input  logic              in_fault,
  input  logic              in_fetch,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [NREG-1:0]   out_sel,
  output logic              out_fault,
  output logic              out_fetch
);
  logic              vld_q, vld_d;
  logic              load_en;
  logic [ADDR_W-1:0] addr_q;
  logic [NREG-1:0]   sel_q;
  logic              fault_q, fetch_q;

  always_comb begin
    in_ready = !vld_q || out_ready;
    load_en  = in_valid && in_ready;
    if (load_en)        vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sel_q   <= '0;
      fault_q <= 1'b0;
      fetch_q <= 1'b0;
    end else if (load_en) begin
      addr_q  <= in_addr;
      sel_q   <= in_sel;
      fault_q <= in_fault;
      fetch_q <= in_fetch;
    end
  end

  assign out_valid = vld_q;
  assign out_addr  = addr_q;
  assign out_sel   = sel_q;
  assign out_fault = fault_q;
  assign out_fetch = fetch_q;

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_sel) && $stable(out_fault));
  assert_noaccept_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_addr == $past(in_addr));
  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_sel));
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int unsigned ADDR_W     = agu_pkg::AGU_ADDR_W,
  parameter int unsigned DISP_W     = agu_pkg::AGU_DISP_W,
  parameter int unsigned SPACE_W    = agu_pkg::AGU_SPACE_W,
  parameter int unsigned RIDX_W     = agu_pkg::AGU_RIDX_W,
  parameter int unsigned NREG       = agu_pkg::RG_NUM,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RIDX_W-1:0] req_ridx,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_fetch,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [NREG-1:0]   rsp_sel,
  output logic              rsp_fault
);
  import agu_pkg::*;
  localparam int unsigned TOP_W = ADDR_W - SPACE_W;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] ea;
  logic [NREG-1:0]   dec_sel;
  logic              dec_fault;
  logic              rsp_fetch;

  agu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  agu_ea_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SPACE_W(SPACE_W), .RIDX_W(RIDX_W)) u_ea (
    .ridx(req_ridx), .base(req_base), .disp(req_disp), .fetch(req_fetch), .ea(ea)
  );

  agu_region_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr(ea), .fetch(req_fetch), .write(req_write), .sel(dec_sel), .fault(dec_fault)
  );

  agu_out_stage #(.ADDR_W(ADDR_W), .NREG(NREG)) u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(ea), .in_sel(dec_sel), .in_fault(dec_fault), .in_fetch(req_fetch),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_addr(rsp_addr), .out_sel(rsp_sel), .out_fault(rsp_fault), .out_fetch(rsp_fetch)
  );

  assert_data_fold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid && !rsp_fetch |-> rsp_addr[ADDR_W-1:SPACE_W] == {TOP_W{rsp_addr[SPACE_W-1]}});
  assert_fetch_mask_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid && rsp_fetch |-> rsp_addr[ADDR_W-1:SPACE_W] == '0);
  assert_bad_faults_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid && rsp_sel[RG_BAD] |-> rsp_fault);
  assert_fault_nosel_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid && rsp_fault |-> (rsp_sel == '0) || rsp_sel[RG_BAD]);
  assert_reset_idle_R11: assert property (@(posedge clk)
    !rst_sync_n |=> !rsp_valid);
endmodule

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_ridx = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic        req_fetch = 1'b0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [3:0]  rsp_sel;
  logic        rsp_fault;

  typedef struct {
    logic [31:0] a;
    logic [3:0]  s;
    logic        f;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_err = 0;
  bit          bp = 1'b0;
  bit          mon_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  agu_top u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ridx(req_ridx), .req_base(req_base), .req_disp(req_disp),
    .req_fetch(req_fetch), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_sel(rsp_sel), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected result built from the requirement text
  function automatic exp_t model(input logic [4:0] r, input logic [31:0] b,
                                 input logic [15:0] d, input bit f, input bit w,
                                 input string tag);
    exp_t e;
    logic [31:0] s;
    logic [31:0] a;
    s = ((r == 5'd0) ? 32'h0 : b) + {{16{d[15]}}, d};          // R1 R2
    a = f ? {6'b0, s[25:0]} : {{6{s[25]}}, s[25:0]};           // R3 R4
    e.s = 4'b0000; e.f = 1'b0; e.a = a; e.tag = tag;
    if (a <= 32'h0000_7FFF) begin                              // R5
      if (!f && w) e.f = 1'b1; else e.s = 4'b0001;
    end else if (f) begin
      if (a >= 32'h03FF_E000 && a <= 32'h03FF_EFFF) e.s = 4'b0010; // R6
      else e.f = 1'b1;                                          // R9
    end else if (a >= 32'hFFFF_E000 && a <= 32'hFFFF_EFFF) e.s = 4'b0010;
    else if (a >= 32'hFFFF_F000) e.s = 4'b0100;                // R7
    else if (a >= 32'hFFFF_8000 && a <= 32'hFFFF_DFFF) begin   // R8
      e.s = 4'b1000; e.f = 1'b1;
    end else e.f = 1'b1;                                        // R9
    return e;
  endfunction

  task automatic send(input logic [4:0] r, input logic [31:0] b, input logic [15:0] d,
                      input bit f, input bit w, input string tag);
    @(posedge clk); #1;
    req_ridx = r; req_base = b; req_disp = d; req_fetch = f; req_write = w;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    q.push_back(model(r, b, d, f, w, tag));
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // consumer ready pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_ready = bp ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // scoreboard monitor
  logic        hold_prev = 1'b0;
  logic [31:0] pa;
  logic [3:0]  ps;
  logic        pf;
  always @(negedge clk) begin
    if (mon_en) begin
      if (hold_prev)
        chk(rsp_valid && rsp_addr == pa && rsp_sel == ps && rsp_fault == pf,
            "R10", "stalled output moved", {rsp_sel, rsp_addr}, {ps, pa});
      if (rsp_valid && !rsp_ready)
        chk(!req_ready, "R10", "req_ready while stalled", 64'(req_ready), 64'd0);
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected result", 64'(rsp_addr), 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_addr == e.a, e.tag, "addr", 64'(rsp_addr), 64'(e.a));
          chk(rsp_sel == e.s, e.tag, "sel", 64'(rsp_sel), 64'(e.s));
          chk(rsp_fault == e.f, e.tag, "fault", 64'(rsp_fault), 64'(e.f));
        end
      end
      hold_prev = rsp_valid && !rsp_ready;
      pa = rsp_addr; ps = rsp_sel; pf = rsp_fault;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 64'(q.size()), 64'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "valid in reset", 64'(rsp_valid), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R11", "ready after reset", 64'(req_ready), 64'd1);
    mon_en = 1'b1;

    // directed, no backpressure
    send(5'd0, 32'hDEAD_BEEF, 16'h0010, 0, 0, "R2");
    send(5'd7, 32'hFFFF_FFFF, 16'h0001, 0, 0, "R1");
    send(5'd0, 32'h1234_5678, 16'h8000, 0, 0, "R1");
    send(5'd0, 32'h0,         16'hE000, 0, 0, "R6");
    send(5'd0, 32'h0,         16'hEFFF, 0, 1, "R6");
    send(5'd0, 32'h0,         16'hF000, 0, 1, "R7");
    send(5'd0, 32'h0,         16'hFFFF, 0, 0, "R7");
    send(5'd0, 32'h0,         16'hDFFF, 0, 0, "R8");
    send(5'd3, 32'h0000_1000, 16'h7FFF, 0, 0, "R9");
    send(5'd1, 32'h0000_7FF0, 16'h0010, 0, 0, "R9");
    send(5'd1, 32'h0000_7FF0, 16'h000F, 0, 0, "R5");
    send(5'd0, 32'h0,         16'h0100, 0, 1, "R5");
    send(5'd2, 32'h0200_0000, 16'h0000, 0, 0, "R3");
    send(5'd2, 32'h07FF_E010, 16'h0000, 0, 0, "R3");
    send(5'd2, 32'h4000_1234, 16'h0000, 0, 0, "R3");
    send(5'd5, 32'hFFFF_E010, 16'h0000, 1, 0, "R4");
    send(5'd5, 32'h03FF_F000, 16'h0000, 1, 0, "R9");
    send(5'd0, 32'h0,         16'h8000, 1, 0, "R9");
    send(5'd6, 32'hC000_0100, 16'h0000, 1, 0, "R4");
    send(5'd0, 32'h0,         16'h0100, 1, 1, "R4");
    send(5'd4, 32'h03FF_EFFF, 16'h0000, 1, 0, "R6");
    idle();
    repeat (3) @(negedge clk);

    // single-cycle latency
    send(5'd0, 32'h0, 16'hF004, 0, 0, "R10");
    idle();
    @(negedge clk);
    chk(rsp_valid && rsp_addr == 32'hFFFF_F004, "R10", "latency",
        64'(rsp_addr), 64'hFFFF_F004);
    repeat (2) @(negedge clk);

    // back-to-back with random backpressure: drain and accept in one edge
    bp = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b;
      case ($urandom % 5)
        0: b = 32'h0;
        1: b = 32'hFFFF_E800;
        2: b = 32'h03FF_E400;
        3: b = 32'h07FF_F000;
        default: b = $urandom;
      endcase
      send(5'($urandom % 4), b, 16'($urandom), 1'($urandom), 1'($urandom), "R10");
    end
    idle();
    bp = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule